// File: doc/BRIEF.md
# Interrupt Status Read-Clear Controller

This block holds the interrupt register, the status register, the sequence-step field and configuration register 1 of a SCSI-style host adapter. It also drives a level interrupt line to the host CPU. Internal logic reports events to it through one-cycle strobes: command done, bus service, disconnect, bus reset, transfer complete, and a command completion that carries a status byte. The block turns each strobe into register contents and raises the interrupt line.

When the host reads the interrupt register, it gets the register's previous contents. The same read clears the pending interrupt. A command completion cannot always be reported at once: it may arrive while an interrupt is still pending, or in the same cycle as a clearing read. In that case the block keeps the completion in a one-entry holding slot. It replays the completion by itself in the first cycle after the read where the interrupt is clear. No completion is therefore dropped or merged into an unread interrupt.

Top module: `int_status_ctrl`

## Requirements
- R1: After reset the interrupt register, the status register, the sequence step and the last status byte are all zero. Config register 1 reads 7 and the interrupt line is low.
- R2: The interrupt line always equals status bit 7 (INT). It rises only in the cycle after an event that raises INT while INT was clear. A raising event while INT is already set leaves the line high, with no new edge.
- R3: The interrupt register is presented combinationally on `intRdData`. In the cycle after a read strobe, the following hold:
  - the interrupt register is zero;
  - status bits 7 (INT) and 4 (TC) are cleared and bits 2:0 are kept;
  - the sequence step is 4 (command done);
  - the interrupt line is low.
- R4: A completion arriving with INT clear, no read and nothing held is reported in the next cycle:
  - status becomes 0x93 (INT, TC and bus phase 3'b011);
  - the interrupt register becomes 0x10 (bus service);
  - the sequence step becomes 0;
  - `lastStatus` becomes the status byte;
  - the interrupt line rises.
- R5: A completion that arrives while INT is set, or in the same cycle as a read strobe, changes no register. Its status byte goes into the holding slot.
- R6: A held completion is reported exactly as in R4, with the held byte, in the first cycle where INT is clear and no read is strobed. The slot holds one entry: a later completion that arrives before the replay replaces the held byte. A completion that arrives in the replay cycle itself is held in turn.
- R7: A bus-reset strobe loads the interrupt register with 0x80. It sets INT only when config register 1 bit 6 is clear. Otherwise the status register is unchanged.
- R8: A disconnect strobe loads the interrupt register with 0x20, zeroes the sequence step and sets INT.
- R9: A transfer-complete strobe sets status bit 4 (TC), loads the interrupt register with 0x10, zeroes the sequence step and sets INT.
- R10: A command-done strobe ORs 0x08 into the interrupt register and a bus-service strobe ORs 0x10 into it. Each sets INT.
- R11: At most one action applies per cycle, in this priority order: read, held replay, live completion, bus reset, disconnect, transfer complete, command done, bus service. Lower-priority event strobes in that cycle have no effect, except that a completion is held under R5/R6.
- R12: A config write makes config register 1 equal to the written byte in the next cycle, independently of every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| intRdEn | input | 1 | Host read strobe of the interrupt register |
| evCmdDone | input | 1 | Command-done event strobe |
| evBusSvc | input | 1 | Bus-service event strobe |
| evDisconnect | input | 1 | Disconnect event strobe |
| evBusReset | input | 1 | Bus-reset command strobe |
| evXferDone | input | 1 | Transfer-complete event strobe |
| evComplete | input | 1 | Command-completion event strobe |
| evStatus | input | 8 | Status byte carried by the completion |
| cfgWrEn | input | 1 | Config register 1 write strobe |
| cfgWrData | input | 8 | Config register 1 write data |
| intRdData | output | 8 | Interrupt register contents (read data) |
| statusOut | output | 8 | Status register |
| seqOut | output | 3 | Sequence-step field |
| cfgOut | output | 8 | Config register 1 |
| lastStatus | output | 8 | Status byte of the last reported completion |
| irqOut | output | 1 | Level interrupt to the host |

## Verification
The bench targets the following cases:
- **Completion in the same cycle as a clearing read.** A design that serviced the completion first would lose it under the read's clear.
- **Completion arriving while an interrupt is pending.** A design that reported it at once would overwrite the unread interrupt contents.
- **Two completions held back to back.** The replay must carry the newer byte.
- **Bus reset with the report-disable bit set, then clear.** A design that ignored the bit would raise the line when reporting is disabled.
- **Simultaneous strobes.** These cover the priority order and the OR-merging of command-done and bus-service bits while INT is already high. A broken design there would show a wrong interrupt byte or an extra interrupt edge.

// File: rtl/isr_pkg.sv
package isr_pkg;
  // status register bit positions
  localparam int INT_BIT = 7;
  localparam int TC_BIT  = 4;
  localparam int PHASE_W = 3;

  // interrupt register codes
  localparam logic [7:0] IRQ_SELECTED = 8'h01;
  localparam logic [7:0] IRQ_FUNCDONE = 8'h08;
  localparam logic [7:0] IRQ_BUSSVC   = 8'h10;
  localparam logic [7:0] IRQ_DISCONN  = 8'h20;
  localparam logic [7:0] IRQ_BUSRST   = 8'h80;

  // bus phase reported with a completion
  localparam logic [2:0] PHASE_STATUS = 3'b011;

  typedef struct packed {
    logic clrRead;    // interrupt-register read side effects
    logic report;     // report a completion
    logic fromSlot;   // report uses the held byte
    logic slotLoad;   // capture evStatus into the holding slot
    logic busReset;
    logic disconnect;
    logic xferDone;
    logic cmdDone;
    logic busSvc;
  } isrStrobe_t;
endpackage

// File: rtl/isr_ctrl.sv
module isr_ctrl
  import isr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       intRdEn,
  input  logic       evCmdDone,
  input  logic       evBusSvc,
  input  logic       evDisconnect,
  input  logic       evBusReset,
  input  logic       evXferDone,
  input  logic       evComplete,
  input  logic       intSet,
  output isrStrobe_t strobe,
  output logic       deferPending
);
  logic replay;
  logic liveReport;
  logic holdNew;

  // held completion goes first once INT is clear and no read is in flight
  assign replay     = deferPending && !intSet && !intRdEn;
  assign liveReport = evComplete && !intSet && !intRdEn && !replay;
  assign holdNew    = evComplete && !liveReport;

  always_comb begin
    strobe          = '0;
    strobe.slotLoad = holdNew;
    if (intRdEn) begin
      strobe.clrRead = 1'b1;
    end else if (replay) begin
      strobe.report   = 1'b1;
      strobe.fromSlot = 1'b1;
    end else if (liveReport) begin
      strobe.report = 1'b1;
    end else if (evBusReset) begin
      strobe.busReset = 1'b1;
    end else if (evDisconnect) begin
      strobe.disconnect = 1'b1;
    end else if (evXferDone) begin
      strobe.xferDone = 1'b1;
    end else if (evCmdDone) begin
      strobe.cmdDone = 1'b1;
    end else if (evBusSvc) begin
      strobe.busSvc = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      deferPending <= 1'b0;
    end else if (holdNew) begin
      deferPending <= 1'b1;
    end else if (replay) begin
      deferPending <= 1'b0;
    end
  end
endmodule

// File: rtl/isr_regs.sv
module isr_regs
  import isr_pkg::*;
#(
  parameter int         DATA_W    = 8,
  parameter int         SEQ_W     = 3,
  parameter logic [7:0] CFG_RESET = 8'h07,
  parameter int         RPT_OFF   = 6,
  parameter int         SEQ_DONE  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  isrStrobe_t        strobe,
  input  logic [DATA_W-1:0] evStatus,
  input  logic              cfgWrEn,
  input  logic [DATA_W-1:0] cfgWrData,
  output logic [DATA_W-1:0] intReg,
  output logic [DATA_W-1:0] statReg,
  output logic [SEQ_W-1:0]  seqReg,
  output logic [DATA_W-1:0] cfgReg,
  output logic [DATA_W-1:0] lastStatus,
  output logic [DATA_W-1:0] slotByte,
  output logic              irq,
  output logic              intSet
);
  localparam logic [DATA_W-1:0] RPT_STAT =
    DATA_W'((1 << TC_BIT) | int'(PHASE_STATUS));

  logic [DATA_W-1:0] intN, statN, lastN;
  logic [SEQ_W-1:0]  seqN;
  logic              raise;

  assign intSet = statReg[INT_BIT];

  always_comb begin
    intN  = intReg;
    statN = statReg;
    seqN  = seqReg;
    lastN = lastStatus;
    raise = 1'b0;
    if (strobe.clrRead) begin
      intN           = '0;
      statN[INT_BIT] = 1'b0;
      statN[TC_BIT]  = 1'b0;
      seqN           = SEQ_W'(SEQ_DONE);
    end else if (strobe.report) begin
      statN = RPT_STAT;
      intN  = DATA_W'(IRQ_BUSSVC);
      seqN  = '0;
      lastN = strobe.fromSlot ? slotByte : evStatus;
      raise = 1'b1;
    end else if (strobe.busReset) begin
      intN  = DATA_W'(IRQ_BUSRST);
      raise = !cfgReg[RPT_OFF];
    end else if (strobe.disconnect) begin
      intN  = DATA_W'(IRQ_DISCONN);
      seqN  = '0;
      raise = 1'b1;
    end else if (strobe.xferDone) begin
      statN[TC_BIT] = 1'b1;
      intN          = DATA_W'(IRQ_BUSSVC);
      seqN          = '0;
      raise         = 1'b1;
    end else if (strobe.cmdDone) begin
      intN  = intReg | DATA_W'(IRQ_FUNCDONE);
      raise = 1'b1;
    end else if (strobe.busSvc) begin
      intN  = intReg | DATA_W'(IRQ_BUSSVC);
      raise = 1'b1;
    end
    if (raise) begin
      statN[INT_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intReg     <= '0;
      statReg    <= '0;
      seqReg     <= '0;
      lastStatus <= '0;
      slotByte   <= '0;
      irq        <= 1'b0;
    end else begin
      intReg     <= intN;
      statReg    <= statN;
      seqReg     <= seqN;
      lastStatus <= lastN;
      irq        <= statN[INT_BIT];
      if (strobe.slotLoad) begin
        slotByte <= evStatus;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= DATA_W'(CFG_RESET);
    end else if (cfgWrEn) begin
      cfgReg <= cfgWrData;
    end
  end
endmodule

// File: rtl/int_status_ctrl.sv
module int_status_ctrl
  import isr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEQ_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              intRdEn,
  input  logic              evCmdDone,
  input  logic              evBusSvc,
  input  logic              evDisconnect,
  input  logic              evBusReset,
  input  logic              evXferDone,
  input  logic              evComplete,
  input  logic [DATA_W-1:0] evStatus,
  input  logic              cfgWrEn,
  input  logic [DATA_W-1:0] cfgWrData,
  output logic [DATA_W-1:0] intRdData,
  output logic [DATA_W-1:0] statusOut,
  output logic [SEQ_W-1:0]  seqOut,
  output logic [DATA_W-1:0] cfgOut,
  output logic [DATA_W-1:0] lastStatus,
  output logic              irqOut
);
  isrStrobe_t        strobe;
  logic              intSet;
  logic              deferPending;
  logic [DATA_W-1:0] slotByte;

  isr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .intRdEn(intRdEn),
    .evCmdDone(evCmdDone), .evBusSvc(evBusSvc), .evDisconnect(evDisconnect),
    .evBusReset(evBusReset), .evXferDone(evXferDone), .evComplete(evComplete),
    .intSet(intSet), .strobe(strobe), .deferPending(deferPending)
  );

  isr_regs #(.DATA_W(DATA_W), .SEQ_W(SEQ_W)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .evStatus(evStatus),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .intReg(intRdData), .statReg(statusOut), .seqReg(seqOut),
    .cfgReg(cfgOut), .lastStatus(lastStatus), .slotByte(slotByte),
    .irq(irqOut), .intSet(intSet)
  );
endmodule

// File: rtl/isr_checker.sv
module isr_checker
  import isr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEQ_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              intRdEn,
  input logic              evComplete,
  input logic [DATA_W-1:0] evStatus,
  input logic              evBusReset,
  input logic              cfgWrEn,
  input logic [DATA_W-1:0] cfgWrData,
  input logic [DATA_W-1:0] intRdData,
  input logic [DATA_W-1:0] statusOut,
  input logic [SEQ_W-1:0]  seqOut,
  input logic [DATA_W-1:0] cfgOut,
  input logic [DATA_W-1:0] lastStatus,
  input logic              irqOut,
  input logic              deferPending
);
  assert_irq_matches_int_R2: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == statusOut[INT_BIT]);

  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    intRdEn |=> (intRdData == '0) && !irqOut && (seqOut == SEQ_W'(4)));

  assert_live_report_R4: assert property (@(posedge clk) disable iff (!rstN)
    evComplete && !statusOut[INT_BIT] && !intRdEn && !deferPending
    |=> (statusOut == DATA_W'(8'h93)) && (lastStatus == $past(evStatus)) && irqOut);

  assert_hold_on_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    evComplete && (statusOut[INT_BIT] || intRdEn) |=> deferPending);

  assert_replay_R6: assert property (@(posedge clk) disable iff (!rstN)
    deferPending && !statusOut[INT_BIT] && !intRdEn
    |=> irqOut && (deferPending == $past(evComplete)));

  assert_reset_masked_R7: assert property (@(posedge clk) disable iff (!rstN)
    evBusReset && cfgOut[6] && !statusOut[INT_BIT] && !intRdEn
      && !deferPending && !evComplete
    |=> !irqOut && (intRdData == DATA_W'(8'h80)));

  assert_cfg_write_R12: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> cfgOut == $past(cfgWrData));
endmodule

bind int_status_ctrl isr_checker #(.DATA_W(DATA_W), .SEQ_W(SEQ_W)) u_chk (.*);

// File: tb/int_status_ctrl_test.sv
module int_status_ctrl_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       intRdEn = 0, evCmdDone = 0, evBusSvc = 0, evDisconnect = 0;
  logic       evBusReset = 0, evXferDone = 0, evComplete = 0, cfgWrEn = 0;
  logic [7:0] evStatus = 0, cfgWrData = 0;
  logic [7:0] intRdData, statusOut, cfgOut, lastStatus;
  logic [2:0] seqOut;
  logic       irqOut;

  int unsigned nChecks = 0;
  int unsigned nFails  = 0;
  bit          done    = 1'b0;

  // bench model of the requirements
  logic [7:0] mInt, mStat, mCfg, mLast, mSlot;
  logic [2:0] mSeq;
  logic       mDefer;
  string      tag;

  int_status_ctrl uut (.*);

  always #10 clk = ~clk;  // 50 MHz

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk(tag, "intRdData", intRdData, mInt);
    chk(tag, "statusOut", statusOut, mStat);
    chk(tag, "seqOut", {5'd0, seqOut}, {5'd0, mSeq});
    chk(tag, "lastStatus", lastStatus, mLast);
    chk("R12", "cfgOut", cfgOut, mCfg);
    chk("R2", "irqOut", {7'd0, irqOut}, {7'd0, mStat[7]});
  endtask

  task automatic modelReset();
    mInt = 0; mStat = 0; mSeq = 0; mLast = 0; mSlot = 0; mDefer = 0; mCfg = 8'h07;
  endtask

  task automatic modelStep();
    bit replay, live, raise;
    replay = mDefer && !mStat[7] && !intRdEn;
    live   = evComplete && !mStat[7] && !intRdEn && !replay;
    raise  = 0;
    tag    = "R11";
    if (intRdEn) begin
      mInt = 0; mStat[7] = 0; mStat[4] = 0; mSeq = 3'd4; tag = "R3";
    end else if (replay || live) begin
      mStat = 8'h13; mInt = 8'h10; mSeq = 0; raise = 1;
      mLast = replay ? mSlot : evStatus;
      tag = replay ? "R6" : "R4";
    end else if (evBusReset) begin
      mInt = 8'h80; raise = !mCfg[6]; tag = "R7";
    end else if (evDisconnect) begin
      mInt = 8'h20; mSeq = 0; raise = 1; tag = "R8";
    end else if (evXferDone) begin
      mStat[4] = 1; mInt = 8'h10; mSeq = 0; raise = 1; tag = "R9";
    end else if (evCmdDone) begin
      mInt |= 8'h08; raise = 1; tag = "R10";
    end else if (evBusSvc) begin
      mInt |= 8'h10; raise = 1; tag = "R10";
    end else if (evComplete) begin
      tag = "R5";
    end
    if (raise) mStat[7] = 1;
    if (evComplete && !live) begin
      mSlot = evStatus; mDefer = 1;
    end else if (replay) begin
      mDefer = 0;
    end
    if (cfgWrEn) mCfg = cfgWrData;
  endtask

  task automatic clearIn();
    intRdEn = 0; evCmdDone = 0; evBusSvc = 0; evDisconnect = 0;
    evBusReset = 0; evXferDone = 0; evComplete = 0; cfgWrEn = 0;
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic step();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
    clearIn();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    modelReset();
    repeat (3) @(negedge clk);
    tag = "R1";
    compareAll();  // R1 reset state
    rstN = 1'b1;

    // R10 then R2: raise while set, no new edge
    evCmdDone = 1; step();
    evBusSvc = 1; step();
    chk("R2", "irq held", {7'd0, irqOut}, 8'd1);
    // R3 read
    intRdEn = 1; step();
    // R4 live completion
    evComplete = 1; evStatus = 8'hA5; step();
    // R5 completion while INT set, then R6 replay after read
    evComplete = 1; evStatus = 8'h3C; step();
    chk("R5", "no update", lastStatus, 8'hA5);
    intRdEn = 1; step();
    chk("R6", "irq low after read", {7'd0, irqOut}, 8'd0);
    step();
    chk("R6", "replayed byte", lastStatus, 8'h3C);
    // R5 completion in the same cycle as a read
    intRdEn = 1; evComplete = 1; evStatus = 8'h77; step();
    step();
    chk("R6", "same-cycle replay", lastStatus, 8'h77);
    // R6 overwrite of held slot
    evComplete = 1; evStatus = 8'h11; step();
    evComplete = 1; evStatus = 8'h22; step();
    intRdEn = 1; step();
    step();
    chk("R6", "newest held byte", lastStatus, 8'h22);
    // R7 with report disabled, then enabled; R12 config write
    intRdEn = 1; cfgWrEn = 1; cfgWrData = 8'h47; step();
    evBusReset = 1; step();
    chk("R7", "masked reset irq", {7'd0, irqOut}, 8'd0);
    cfgWrEn = 1; cfgWrData = 8'h07; step();
    evBusReset = 1; step();
    chk("R7", "unmasked reset irq", {7'd0, irqOut}, 8'd1);
    // R11 priority, R8, R9
    intRdEn = 1; step();
    evDisconnect = 1; evXferDone = 1; evCmdDone = 1; step();
    intRdEn = 1; step();
    evXferDone = 1; evBusSvc = 1; step();
    idle(2);

    // constrained random mix
    for (int i = 0; i < 5000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      intRdEn      = (r < 15);
      evCmdDone    = ($urandom_range(0, 9) == 0);
      evBusSvc     = ($urandom_range(0, 9) == 0);
      evDisconnect = ($urandom_range(0, 19) == 0);
      evBusReset   = ($urandom_range(0, 29) == 0);
      evXferDone   = ($urandom_range(0, 14) == 0);
      evComplete   = ($urandom_range(0, 7) == 0);
      evStatus     = 8'($urandom);
      cfgWrEn      = ($urandom_range(0, 39) == 0);
      cfgWrData    = {1'b0, 1'($urandom), 6'h07};
      step();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule